// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word that a floating-point unit keeps beside its arithmetic. Software reads and writes the whole word through one port. The hardware side has two update paths. One takes the outcome of a compare and sets the four condition flags in the top nibble. The other takes a per-operation vector of exception pulses and accumulates them into sticky bits.

The block sends the two-bit rounding field to the arithmetic datapath as a one-hot mode vector. The vector-length and vector-stride fields are stored apart from the main word. The read path puts them back into their bit positions. The accumulated exception bits are ORed into bits 4:0 of every read.

Top module: `fpsc_unit`

## Requirements
- R1: After reset, `sw_rd_data` reads 32'h0 and `round_mode` is 4'b0001 (nearest-even).
- R2: A compare updates only bits 31:28 of the register. The `cmp_result` encoding is 0=equal, 1=less, 2=greater, 3=unordered. These give the nibbles 4'b0110, 4'b1000, 4'b0010 and 4'b0011. Bits 27:5 read back unchanged.
- R3: A software write of D makes the next read return D with D[12:8] ORed into bits 4:0. Storage is split: D AND 32'hFFC8FFFF goes to the main word, bits 18:16 go to the length field and bits 21:20 go to the stride field.
- R4: `round_mode` decodes register bits 23:22 as follows: 0 drives bit0 (nearest-even), 1 drives bit1 (toward +inf), 2 drives bit2 (toward -inf), 3 drives bit3 (toward zero). Exactly one bit is high at any time.
- R5: The exception bit order is invalid=0, divide-by-zero=1, overflow=2, underflow=3, inexact=4. Each bit of `exc_pulse` at that position is ORed into read bits 4:0.
- R6: Exception bits are sticky. Pulses and compares never clear them. Only a software write, which loads them from D[12:8], or a reset can clear them.
- R7: A signalling compare (`cmp_signalling`=1) with an unordered result also sets the invalid bit (bit 0). A quiet compare never sets it.
- R8: When a software write happens in the same cycle as a compare and/or a pulse, the next read equals the R3 value of the write alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write data |
| sw_rd_data | output | 32 | Current register value as read by software |
| cmp_valid | input | 1 | A compare outcome is present this cycle |
| cmp_result | input | 2 | Compare outcome: 0 equal, 1 less, 2 greater, 3 unordered |
| cmp_signalling | input | 1 | The compare is the signalling variant |
| exc_pulse | input | 5 | Per-operation exception pulses, in R5 bit order |
| round_mode | output | 4 | One-hot rounding mode for the datapath |

## Verification
The bench drives each of the four compare outcomes in turn. A mapping swap between any two nibbles therefore shows up, and so does a write that spills below bit 28. The unordered outcome is issued twice, once quiet and once signalling, which separates the invalid side effect from the flag update. Software writes use words with nonzero length, stride, rounding and bits 12:8. These expose a wrong mask, a missing field re-insertion or a wrong exception source. Pulses that repeat an already-set bit, and a write that happens together with a compare and a pulse, show whether the sticky logic and the update priority are right.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
    localparam int REG_W       = 32;
    localparam int LEN_LSB     = 16;
    localparam int LEN_W       = 3;
    localparam int STR_LSB     = 20;
    localparam int STR_W       = 2;
    localparam int RM_LSB      = 22;
    localparam int RM_W        = 2;
    localparam int RM_N        = 1 << RM_W;
    localparam int EXC_W       = 5;
    localparam int EXC_SRC_LSB = 8;
    localparam int FLAG_LSB    = 28;
    localparam int FLAG_W      = 4;
    localparam int EXC_INVALID = 0;

    localparam logic [REG_W-1:0] FIELD_BITS =
        (REG_W'((1 << LEN_W) - 1) << LEN_LSB) |
        (REG_W'((1 << STR_W) - 1) << STR_LSB);
    localparam logic [REG_W-1:0] KEEP_MASK = ~FIELD_BITS;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_LT = 2'd1,
        CMP_GT = 2'd2,
        CMP_UN = 2'd3
    } cmp_res_e;

    typedef struct packed {
        logic [REG_W-1:0] main;
        logic [LEN_W-1:0] vlen;
        logic [STR_W-1:0] vstr;
        logic [EXC_W-1:0] exc;
    } fpsc_state_t;
endpackage

// File: rtl/fpsc_cmp_map.sv
module fpsc_cmp_map
    import fpsc_pkg::*;
(
    input  cmp_res_e            res,
    input  logic                signalling,
    output logic [FLAG_W-1:0]   nzcv,
    output logic                raise_invalid
);
    always_comb begin
        unique case (res)
            CMP_EQ:  nzcv = 4'b0110;
            CMP_LT:  nzcv = 4'b1000;
            CMP_GT:  nzcv = 4'b0010;
            default: nzcv = 4'b0011;
        endcase
        raise_invalid = signalling && (res == CMP_UN);
    end
endmodule

// File: rtl/fpsc_rmode_dec.sv
module fpsc_rmode_dec
    import fpsc_pkg::*;
(
    input  logic [RM_W-1:0] code,
    output logic [RM_N-1:0] onehot
);
    for (genvar i = 0; i < RM_N; i++) begin : g_dec
        assign onehot[i] = (code == RM_W'(i));
    end
endmodule

// File: rtl/fpsc_rd_merge.sv
module fpsc_rd_merge
    import fpsc_pkg::*;
(
    input  fpsc_state_t       st,
    output logic [REG_W-1:0]  rd
);
    always_comb begin
        rd = (st.main & KEEP_MASK)
           | (REG_W'(st.vlen) << LEN_LSB)
           | (REG_W'(st.vstr) << STR_LSB)
           | REG_W'(st.exc);
    end
endmodule

// File: rtl/fpsc_unit.sv
module fpsc_unit
    import fpsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_en,
    input  logic [REG_W-1:0]  sw_wr_data,
    output logic [REG_W-1:0]  sw_rd_data,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_result,
    input  logic              cmp_signalling,
    input  logic [EXC_W-1:0]  exc_pulse,
    output logic [RM_N-1:0]   round_mode
);
    fpsc_state_t       state_d, state_q;
    logic [FLAG_W-1:0] nzcv;
    logic              raise_inv;

    fpsc_cmp_map u_cmp (
        .res           (cmp_res_e'(cmp_result)),
        .signalling    (cmp_signalling),
        .nzcv          (nzcv),
        .raise_invalid (raise_inv)
    );

    always_comb begin
        state_d = state_q;
        state_d.exc = state_q.exc | exc_pulse;
        if (cmp_valid) begin
            state_d.main[FLAG_LSB +: FLAG_W] = nzcv;
            if (raise_inv) begin
                state_d.exc[EXC_INVALID] = 1'b1;
            end
        end
        if (sw_wr_en) begin
            state_d.main = sw_wr_data & KEEP_MASK;
            state_d.vlen = sw_wr_data[LEN_LSB +: LEN_W];
            state_d.vstr = sw_wr_data[STR_LSB +: STR_W];
            state_d.exc  = sw_wr_data[EXC_SRC_LSB +: EXC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    fpsc_rd_merge u_rd (
        .st (state_q),
        .rd (sw_rd_data)
    );

    fpsc_rmode_dec u_rm (
        .code   (state_q.main[RM_LSB +: RM_W]),
        .onehot (round_mode)
    );

    AST_CMP_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !sw_wr_en) |=> (sw_rd_data[FLAG_LSB-1:EXC_W] == $past(sw_rd_data[FLAG_LSB-1:EXC_W]))); // R2

    AST_RMODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(round_mode) == 1); // R4

    AST_EXC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en |=> ((sw_rd_data[EXC_W-1:0] & $past(sw_rd_data[EXC_W-1:0])) == $past(sw_rd_data[EXC_W-1:0]))); // R6

    AST_QUIET_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_signalling && !exc_pulse[EXC_INVALID] && !sw_wr_en)
        |=> (sw_rd_data[EXC_INVALID] == $past(sw_rd_data[EXC_INVALID]))); // R7

    AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (sw_rd_data[REG_W-1:FLAG_LSB] == $past(sw_wr_data[REG_W-1:FLAG_LSB]))); // R8
endmodule

// File: tb/fpsc_unit_bench.sv
`timescale 1ns/1ps
module fpsc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic [31:0] sw_rd_data;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_result = '0;
    logic        cmp_signalling = 1'b0;
    logic [4:0]  exc_pulse = '0;
    logic [3:0]  round_mode;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fpsc_unit u_fpsc_unit (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .sw_rd_data(sw_rd_data), .cmp_valid(cmp_valid), .cmp_result(cmp_result),
        .cmp_signalling(cmp_signalling), .exc_pulse(exc_pulse), .round_mode(round_mode)
    );

    // row: {op[1:0] (0 write,1 compare,2 pulse), data[31:0], res[1:0], sig, pulse[4:0], exp_rd[31:0], exp_rm[3:0]}
    localparam int NV = 15;
    localparam logic [77:0] VEC [NV] = '{
        {2'd0, 32'h00000000, 2'd0, 1'b0, 5'h00, 32'h00000000, 4'b0001},
        {2'd1, 32'h00000000, 2'd0, 1'b0, 5'h00, 32'h60000000, 4'b0001},
        {2'd1, 32'h00000000, 2'd1, 1'b0, 5'h00, 32'h80000000, 4'b0001},
        {2'd1, 32'h00000000, 2'd2, 1'b0, 5'h00, 32'h20000000, 4'b0001},
        {2'd1, 32'h00000000, 2'd3, 1'b0, 5'h00, 32'h30000000, 4'b0001},
        {2'd1, 32'h00000000, 2'd3, 1'b1, 5'h00, 32'h30000001, 4'b0001},
        {2'd2, 32'h00000000, 2'd0, 1'b0, 5'h10, 32'h30000011, 4'b0001},
        {2'd1, 32'h00000000, 2'd0, 1'b1, 5'h00, 32'h60000011, 4'b0001},
        {2'd0, 32'h0ABCDEF0, 2'd0, 1'b0, 5'h00, 32'h0ABCDEFE, 4'b0100},
        {2'd2, 32'h00000000, 2'd0, 1'b0, 5'h02, 32'h0ABCDEFE, 4'b0100},
        {2'd0, 32'h00C00000, 2'd0, 1'b0, 5'h00, 32'h00C00000, 4'b1000},
        {2'd0, 32'h00400000, 2'd0, 1'b0, 5'h00, 32'h00400000, 4'b0010},
        {2'd0, 32'h003F0000, 2'd0, 1'b0, 5'h00, 32'h003F0000, 4'b0001},
        {2'd1, 32'h00000000, 2'd2, 1'b0, 5'h00, 32'h203F0000, 4'b0001},
        {2'd2, 32'h00000000, 2'd0, 1'b0, 5'h0C, 32'h203F000C, 4'b0001}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sw_wr_en = 1'b0; cmp_valid = 1'b0; cmp_signalling = 1'b0;
        exc_pulse = '0; sw_wr_data = '0; cmp_result = '0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset read", sw_rd_data, 32'h0);
        check("R1 reset rmode", {28'h0, round_mode}, 32'h1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [31:0] d, er;
            logic [1:0]  rs;
            logic        sg;
            logic [4:0]  pl;
            logic [3:0]  rm;
            string       tag;
            {op, d, rs, sg, pl, er, rm} = VEC[i];
            @(negedge clk);
            sw_wr_en = (op == 2'd0);
            sw_wr_data = d;
            cmp_valid = (op == 2'd1);
            cmp_result = rs;
            cmp_signalling = sg;
            exc_pulse = pl;
            @(negedge clk);
            idle_inputs();
            if (op == 2'd0)      tag = "R3 write";
            else if (op == 2'd2) tag = "R5 R6 pulse";
            else if (rs == 2'd3) tag = "R2 R7 unordered";
            else                 tag = "R2 compare";
            check(tag, sw_rd_data, er);
            check("R4 rmode", {28'h0, round_mode}, {28'h0, rm});
        end

        // R6: idle cycles keep sticky bits
        repeat (4) @(negedge clk);
        check("R6 sticky idle", sw_rd_data, 32'h203F000C);

        // R8: write with compare and pulse in the same cycle
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = 32'h12345000;
        cmp_valid = 1'b1; cmp_result = 2'd1; cmp_signalling = 1'b1;
        exc_pulse = 5'h1F;
        @(negedge clk);
        idle_inputs();
        check("R8 write wins", sw_rd_data, 32'h12345010);

        // R2 R5: compare and pulse together, no write
        @(negedge clk);
        cmp_valid = 1'b1; cmp_result = 2'd0; exc_pulse = 5'h01;
        @(negedge clk);
        idle_inputs();
        check("R2 R5 compare+pulse", sw_rd_data, 32'h62345011);

        // R6: write clears sticky bits
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = 32'h00000000;
        @(negedge clk);
        idle_inputs();
        check("R6 write clears", sw_rd_data, 32'h0);

        // R1: reset mid-run
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = 32'hFFFFFFFF;
        @(negedge clk);
        idle_inputs();
        check("R3 all ones", sw_rd_data, 32'hFFFFFFFF);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", sw_rd_data, 32'h0);
        check("R1 rmode again", {28'h0, round_mode}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule